// File: doc/BRIEF.md
# Pin Event Control Register

This block holds the control word for a single pin and watches that pin for a programmed event. Software writes the word through a plain write port. The word carries a 4-bit event configuration, a lock bit, a 3-bit function-select field and a sticky event flag. The pin input first passes through a synchronizer. A detector then compares the synchronized sample with the one taken a cycle earlier. It recognises rising edges, falling edges, either edge, a held-low level or a held-high level, depending on the configuration.

Once a detection occurs, the flag stays set. The configuration code decides whether the flag is presented as an interrupt or as a DMA request. In DMA codes, a completion pulse from the DMA engine clears the flag. In every code, software can also clear it by writing a 1 to the flag bit. Setting the lock bit freezes the lower sixteen bits of the word until the next reset. The configuration field and the flag stay writable while the lock is set.

The write port has no back-pressure. It carries no stream, so it uses a single enable with no ready signal, and every enabled write is taken on the clock edge where it is presented. The read value is a live view of the word.

Top module: `pin_event_ctl`

## Requirements
- R1: After reset, the read word is 0, and both the interrupt and DMA request outputs are 0.
- R2: A write loads the configuration code into bits 19:16, the lock bit into bit 15 and the function select into bits 10:8. The new value shows on the read word in the next cycle. The function select also drives the mux_sel output.
- R3: Bits 31:25, 23:20, 14:11 and 7:0 of the read word always read 0, whatever value is written to them.
- R4: With code 1001 (interrupt, rising edge), a 0-to-1 change of the pin sets the flag (bit 24) and raises irq_out. A 1-to-0 change does not set the flag. The flag stays set after the pin returns low.
- R5: Writing a 1 to bit 24 clears the flag in the next cycle, unless a detection happens in that same cycle. Writing a 0 to bit 24 leaves the flag unchanged.
- R6: Code 1010 sets the flag only on a falling edge. Code 1011 sets it on either edge.
- R7: Code 1100 sets the flag while the synchronized pin is 1. Code 1000 sets it while the pin is 0. If the pin is still at the active level when a clear is written, the flag stays set.
- R8: Codes 0001, 0010 and 0011 detect the rising edge, the falling edge and either edge. In these codes the flag drives dma_req_out, and irq_out stays 0. A dma_done pulse clears the flag in the next cycle.
- R9: In interrupt codes, dma_done has no effect on the flag.
- R10: Code 0000 and all codes not listed above never set the flag. With any of these codes, both request outputs stay 0.
- R11: Once bit 15 is 1, writes leave bits 15:0 unchanged. Bits 19:16 and the flag clear still respond to writes. Only a reset releases the lock.
- R12: When a detection and a write-1 clear fall in the same cycle, the flag ends up set.
- R13: mux_sel always equals the function-select field held in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the control word |
| wr_data | input | 32 | Write value; bit 24 is write-1-to-clear |
| rd_data | output | 32 | Current control word |
| pin_in | input | 1 | Asynchronous pin level |
| dma_done | input | 1 | DMA transfer completion pulse |
| irq_out | output | 1 | Interrupt request (flag in interrupt codes) |
| dma_req_out | output | 1 | DMA request (flag in DMA codes) |
| mux_sel | output | 3 | Selected pin function |

## Verification
A write becomes visible on rd_data and mux_sel one clock edge after it is presented. A write-1 clear or a dma_done pulse shows on the outputs after one edge as well. A pin change needs three edges before it reaches irq_out or dma_req_out: two for the synchronizer and one for the flag. The set-over-clear case is hit by presenting the clear on the third of those edges. The driver counts clock edges and enqueues every expectation tagged with the exact cycle in which it becomes due. The monitor samples on the falling clock edge and compares only the items due in that cycle, so no result is read early or late.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int REG_W    = 32;
  localparam int FLAG_BIT = 24;
  localparam int CFG_LSB  = 16;
  localparam int CFG_W    = 4;
  localparam int LOCK_BIT = 15;
  localparam int MUX_LSB  = 8;
  localparam int MUX_W    = 3;

  typedef enum logic [CFG_W-1:0] {
    CFG_OFF      = 4'b0000,
    CFG_DMA_RISE = 4'b0001,
    CFG_DMA_FALL = 4'b0010,
    CFG_DMA_BOTH = 4'b0011,
    CFG_IRQ_LOW  = 4'b1000,
    CFG_IRQ_RISE = 4'b1001,
    CFG_IRQ_FALL = 4'b1010,
    CFG_IRQ_BOTH = 4'b1011,
    CFG_IRQ_HIGH = 4'b1100
  } evt_cfg_e;

  typedef struct packed {
    logic dma_mode;
    logic irq_mode;
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
  } cfg_dec_t;

  function automatic cfg_dec_t decode_cfg(logic [CFG_W-1:0] c);
    cfg_dec_t d;
    d = '0;
    case (c)
      CFG_DMA_RISE: begin d.dma_mode = 1'b1; d.on_rise = 1'b1; end
      CFG_DMA_FALL: begin d.dma_mode = 1'b1; d.on_fall = 1'b1; end
      CFG_DMA_BOTH: begin d.dma_mode = 1'b1; d.on_rise = 1'b1; d.on_fall = 1'b1; end
      CFG_IRQ_LOW:  begin d.irq_mode = 1'b1; d.on_low = 1'b1; end
      CFG_IRQ_RISE: begin d.irq_mode = 1'b1; d.on_rise = 1'b1; end
      CFG_IRQ_FALL: begin d.irq_mode = 1'b1; d.on_fall = 1'b1; end
      CFG_IRQ_BOTH: begin d.irq_mode = 1'b1; d.on_rise = 1'b1; d.on_fall = 1'b1; end
      CFG_IRQ_HIGH: begin d.irq_mode = 1'b1; d.on_high = 1'b1; end
      default:      d = '0;
    endcase
    return d;
  endfunction

  function automatic logic cfg_active(logic [CFG_W-1:0] c);
    cfg_dec_t d;
    d = decode_cfg(c);
    return d.dma_mode | d.irq_mode;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic smp_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= 1'b0;
    else        prev_o <= chain_q[STAGES-1];
  end

  assign smp_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_detect.sv
module evt_detect
  import pcr_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             smp,
  input  logic             prev,
  output logic             hit,
  output logic             dma_mode,
  output logic             irq_mode
);
  cfg_dec_t dec;
  logic     rise, fall;

  always_comb begin
    dec      = decode_cfg(cfg);
    rise     = smp & ~prev;
    fall     = ~smp & prev;
    hit      = (dec.on_rise & rise) | (dec.on_fall & fall) |
               (dec.on_high & smp)  | (dec.on_low & ~smp);
    dma_mode = dec.dma_mode;
    irq_mode = dec.irq_mode;
  end
endmodule

// File: rtl/pcr_regs.sv
module pcr_regs
  import pcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hit,
  input  logic             dma_clr,
  output logic [CFG_W-1:0] cfg_q,
  output logic             lock_q,
  output logic [MUX_W-1:0] mux_q,
  output logic             flag_q
);
  logic sw_clr;
  logic flag_d;
  logic unused_wr_bits;

  assign sw_clr = wr_en & wr_data[FLAG_BIT];
  assign unused_wr_bits = ^{wr_data[REG_W-1:FLAG_BIT+1],
                            wr_data[FLAG_BIT-1:CFG_LSB+CFG_W],
                            wr_data[LOCK_BIT-1:MUX_LSB+MUX_W],
                            wr_data[MUX_LSB-1:0]};

  always_comb begin
    if (hit)                  flag_d = 1'b1;
    else if (sw_clr | dma_clr) flag_d = 1'b0;
    else                      flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
      mux_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_en) begin
        cfg_q <= wr_data[CFG_LSB +: CFG_W];
        if (!lock_q) begin
          lock_q <= wr_data[LOCK_BIT];
          mux_q  <= wr_data[MUX_LSB +: MUX_W];
        end
      end
    end
  end

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(mux_q)));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !hit && !sw_clr && !dma_clr) |=> flag_q);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
endmodule

// File: rtl/pin_event_ctl.sv
module pin_event_ctl
  import pcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             pin_in,
  input  logic             dma_done,
  output logic             irq_out,
  output logic             dma_req_out,
  output logic [MUX_W-1:0] mux_sel
);
  logic             smp, prev;
  logic             hit, dma_mode, irq_mode;
  logic [CFG_W-1:0] cfg_q;
  logic             lock_q, flag_q;
  logic [MUX_W-1:0] mux_q;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .smp_o(smp), .prev_o(prev)
  );

  evt_detect u_det (
    .cfg(cfg_q), .smp(smp), .prev(prev),
    .hit(hit), .dma_mode(dma_mode), .irq_mode(irq_mode)
  );

  pcr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hit(hit), .dma_clr(dma_done & dma_mode),
    .cfg_q(cfg_q), .lock_q(lock_q), .mux_q(mux_q), .flag_q(flag_q)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[FLAG_BIT]            = flag_q;
    rd_data[CFG_LSB +: CFG_W]    = cfg_q;
    rd_data[LOCK_BIT]            = lock_q;
    rd_data[MUX_LSB +: MUX_W]    = mux_q;
  end

  assign irq_out     = flag_q & irq_mode;
  assign dma_req_out = flag_q & dma_mode;
  assign mux_sel     = mux_q;

  // R4
  rise_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_IRQ_RISE && smp && !prev && !wr_en) |=> irq_out);

  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_out && dma_req_out));

  // R10
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active(cfg_q) |-> (!irq_out && !dma_req_out));
endmodule

// File: tb/sim_pin_event_ctl.sv
module sim_pin_event_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pin_in = 1'b0;
  logic        dma_done = 1'b0;
  logic        irq_out, dma_req_out;
  logic [2:0]  mux_sel;

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  pin_event_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .dma_done(dma_done),
    .irq_out(irq_out), .dma_req_out(dma_req_out), .mux_sel(mux_sel)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 irq_out, 1 dma_req_out, 2 rd_data, 3 mux_sel
  task automatic expect_at(int d, int kind, logic [31:0] v, string tag);
    exp_t e;
    int i;
    e.due = cyc + d; e.kind = kind; e.val = v; e.tag = tag;
    i = 0;
    while (i < q.size() && q[i].due <= e.due) i++;
    q.insert(i, e);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic dma_pulse();
    dma_done = 1'b1;
    step(1);
    dma_done = 1'b0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      case (e.kind)
        0:       act = {31'd0, irq_out};
        1:       act = {31'd0, dma_req_out};
        2:       act = rd_data;
        default: act = {29'd0, mux_sel};
      endcase
      checks++;
      if (act !== e.val) begin
        errs++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 e.tag, e.kind, cyc, act, e.val);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(1, 2, 32'h0, "R1");
    expect_at(1, 0, 32'h0, "R1");
    expect_at(1, 1, 32'h0, "R1");
    step(2);

    // R3 reserved bits
    wr(32'hFEF0_7FFF);
    expect_at(1, 2, 32'h0000_0700, "R3");
    step(2);
    // R2 field load, R13 mux output
    wr(32'h0009_0300);
    expect_at(1, 2, 32'h0009_0300, "R2");
    expect_at(1, 3, 32'd3, "R13");
    step(2);

    // R4 rising edge interrupt, sticky
    pin_in = 1'b1;
    expect_at(3, 0, 32'd1, "R4");
    expect_at(3, 1, 32'd0, "R4");
    step(5);
    pin_in = 1'b0;
    expect_at(4, 0, 32'd1, "R4");
    step(5);
    expect_at(1, 2, 32'h0109_0300, "R4");
    step(2);
    // R5 write-0 keeps, write-1 clears
    wr(32'h0009_0300);
    expect_at(1, 0, 32'd1, "R5");
    step(2);
    wr(32'h0109_0300);
    expect_at(1, 0, 32'd0, "R5");
    step(2);

    // R12 set beats clear in the same cycle
    pin_in = 1'b1;
    step(2);
    wr(32'h0109_0300);
    expect_at(1, 0, 32'd1, "R12");
    step(2);
    wr(32'h0109_0300);
    expect_at(1, 0, 32'd0, "R5");
    step(2);
    pin_in = 1'b0;
    expect_at(4, 0, 32'd0, "R4");
    step(5);

    // R6 falling only
    wr(32'h010A_0300);
    pin_in = 1'b1;
    expect_at(4, 0, 32'd0, "R6");
    step(5);
    pin_in = 1'b0;
    expect_at(3, 0, 32'd1, "R6");
    step(5);
    // R6 either edge
    wr(32'h010B_0300);
    expect_at(1, 0, 32'd0, "R6");
    step(2);
    pin_in = 1'b1;
    expect_at(3, 0, 32'd1, "R6");
    step(5);
    wr(32'h010B_0300);
    step(2);
    pin_in = 1'b0;
    expect_at(3, 0, 32'd1, "R6");
    step(5);

    // R7 level high with re-set after clear
    wr(32'h010C_0300);
    expect_at(1, 0, 32'd0, "R7");
    step(2);
    pin_in = 1'b1;
    expect_at(3, 0, 32'd1, "R7");
    step(5);
    wr(32'h010C_0300);
    expect_at(1, 0, 32'd1, "R7");
    expect_at(2, 0, 32'd1, "R7");
    step(2);
    pin_in = 1'b0;
    step(4);
    wr(32'h010C_0300);
    expect_at(1, 0, 32'd0, "R7");
    step(2);
    // R7 level low
    wr(32'h0108_0300);
    expect_at(2, 0, 32'd1, "R7");
    step(3);
    pin_in = 1'b1;
    step(4);
    wr(32'h0108_0300);
    expect_at(1, 0, 32'd0, "R7");
    step(2);

    // R8 DMA rising
    wr(32'h0101_0300);
    pin_in = 1'b0;
    step(4);
    pin_in = 1'b1;
    expect_at(3, 1, 32'd1, "R8");
    expect_at(3, 0, 32'd0, "R8");
    step(5);
    dma_pulse();
    expect_at(1, 1, 32'd0, "R8");
    step(2);
    // R8 DMA falling
    wr(32'h0102_0300);
    step(1);
    pin_in = 1'b0;
    expect_at(3, 1, 32'd1, "R8");
    step(5);
    dma_pulse();
    expect_at(1, 1, 32'd0, "R8");
    expect_at(1, 2, 32'h0002_0300, "R8");
    step(2);

    // R9 dma_done ignored in interrupt code
    wr(32'h0109_0300);
    pin_in = 1'b1;
    step(5);
    dma_pulse();
    expect_at(1, 0, 32'd1, "R9");
    step(2);
    wr(32'h0109_0300);
    step(2);

    // R10 reserved and disabled codes
    wr(32'h0105_0300);
    pin_in = 1'b0;
    step(4);
    pin_in = 1'b1;
    step(4);
    expect_at(1, 2, 32'h0005_0300, "R10");
    expect_at(1, 0, 32'd0, "R10");
    expect_at(1, 1, 32'd0, "R10");
    step(2);
    wr(32'h000F_0300);
    pin_in = 1'b0;
    step(5);
    expect_at(1, 2, 32'h000F_0300, "R10");
    step(2);
    wr(32'h0000_0300);
    pin_in = 1'b1;
    step(5);
    expect_at(1, 2, 32'h0000_0300, "R10");
    step(2);

    // R11 lock behaviour
    pin_in = 1'b0;
    wr(32'h0000_8200);
    expect_at(1, 2, 32'h0000_8200, "R11");
    step(4);
    wr(32'h0009_0500);
    expect_at(1, 2, 32'h0009_8200, "R11");
    expect_at(1, 3, 32'd2, "R11");
    step(2);
    pin_in = 1'b1;
    expect_at(3, 0, 32'd1, "R11");
    step(5);
    wr(32'h0109_0000);
    expect_at(1, 2, 32'h0009_8200, "R11");
    step(2);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    expect_at(1, 2, 32'h0, "R11");
    step(2);
    wr(32'h0000_0400);
    expect_at(1, 2, 32'h0000_0400, "R11");
    expect_at(1, 3, 32'd4, "R13");
    step(6);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule